// File: doc/BRIEF.md
# Data Cache Maintenance Sequencer

This block accepts one cache maintenance request at a time and converts it into a stream of single-cycle commands for a cache control unit. A request names an operation (discard, write back, or write back and then discard), a scope (the whole cache or an address range) and, for a range, a start address and a byte length. The block emits command strobes carrying a command kind, an address and a data word. For write-back operations it holds until the control unit reports that its flush has drained, and then pulses `done_o`.

A range request is expanded line by line. The start is rounded down to a line boundary, and the length is extended by the bytes that rounding added and then rounded up to whole lines. When the separate-tag parameter is set, a tag-register write carrying the same physical address precedes every per-line command. The unit's invalidate command discards dirty lines by default. Write-back-and-discard therefore reuses the invalidate family. Around it the block writes the control register twice: first with the invalidate-mode bit set, then, once the flush has drained, with that bit cleared. Both control words keep the cache-disable bit (bit 0) at 0, so the cache stays enabled.

States and transitions:
- IDLE: ready is high. An accepted request goes to one of three states:
  - SETMODE for code 3.
  - DONE for code 0.
  - The first issue state otherwise.
- SETMODE: writes the control register with the invalidate-mode bit set. It then goes to the first issue state.
- The first issue state is chosen as follows:
  - WHOLE for a whole-cache request.
  - TAG or LINE for a range request with at least one line.
  - The post state for an empty range.
- WHOLE: issues one whole-cache command with data 1, then goes to the post state.
- TAG writes the tag register and goes to LINE.
- LINE issues one per-line command. It goes back to TAG (or LINE) while lines remain, and to the post state after the last line.
- The post state is WAIT when operation bit 1 is set, and DONE otherwise.
- WAIT: stays until the flush-busy input reads low. It then goes to RESTORE for code 3 and to DONE otherwise.
- RESTORE writes the control register with the invalidate-mode bit cleared and goes to DONE.
- DONE pulses `done_o` and returns to IDLE.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: A whole-cache request issues exactly one command with data 1.
  - That command is invalidate-all (kind 1) when operation bit 0 is set (codes 1 and 3).
  - It is flush-all (kind 2) for code 2.
- R2: A range request issues ceil(((addr mod L) + len) / L) per-line commands, where L is LINE_BYTES.
  - The addresses are floor(addr / L)·L plus k·L, for k = 0, 1, and so on.
  - The kind is invalidate-line (kind 4) when operation bit 0 is set, and flush-line (kind 5) otherwise.
- R3: With SEP_TAG=1, each per-line command comes directly after a tag write (kind 3) carrying the same address.
- R4: Code 3 starts with a control write (kind 0) of data 0x02. In that word bit 1 is the invalidate-mode bit and bit 0, the cache-disable bit, is 0. This write comes before any maintenance command, and `inv_mode_o` is high while the maintenance commands issue.
- R5: Codes 2 and 3 do not complete until the flush-busy input has been sampled low. Code 1 completes without looking at flush-busy, even while it is held high.
- R6: Code 3 ends with a control write of data 0x00, issued only after flush-busy was sampled low. `inv_mode_o` is low whenever the block is idle.
- R7: `req_ready` is low from the cycle after acceptance until `done_o`. Requests presented during that time are ignored, and `done_o` is a single-cycle pulse.
- R8: Code 0 issues no command and completes with a `done_o` pulse.
- R9: A range whose rounded length is zero lines (aligned start, zero length) issues no per-line or tag command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 2 | Operation: 0 none, 1 discard, 2 write back, 3 write back and discard |
| req_whole | input | 1 | 1 = whole cache, 0 = address range |
| req_addr | input | ADDR_W | Range start address (physical) |
| req_len | input | LEN_W | Range length in bytes |
| flush_busy_i | input | 1 | Flush-in-progress status from the cache unit |
| cmd_valid | output | 1 | Command strobe |
| cmd_kind | output | 3 | 0 ctrl write, 1 inv-all, 2 flush-all, 3 tag write, 4 inv-line, 5 flush-line |
| cmd_addr | output | ADDR_W | Line address for tag and per-line commands, else 0 |
| cmd_data | output | 8 | Control word for ctrl writes, 1 for whole-cache commands, else 0 |
| inv_mode_o | output | 1 | Current invalidate-mode bit (1 = write back before discard) |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- `done_o` lasts one cycle.
- The mode bit is clear whenever the block is idle.
- RESTORE is entered only after flush-busy was sampled low.
- Only write-back operations reach WAIT.
- Per-line commands directly follow a matching tag write.
- The line counter never steps past zero.

The bench's scenarios show what no single-cycle property can:
- The exact command sequence for each operation, including line counts and addresses for unaligned ranges.
- That code 1 finishes while flush-busy is forced high.
- That requests presented while the block is busy leave no trace in the command stream.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    localparam int CTRL_W         = 8;
    localparam int CTRL_DIS_BIT   = 0;
    localparam int CTRL_IMODE_BIT = 1;

    typedef enum logic [2:0] {
        CK_CTRL       = 3'd0,
        CK_INV_ALL    = 3'd1,
        CK_FLUSH_ALL  = 3'd2,
        CK_TAG        = 3'd3,
        CK_INV_LINE   = 3'd4,
        CK_FLUSH_LINE = 3'd5
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETMODE,
        ST_WHOLE,
        ST_TAG,
        ST_LINE,
        ST_WAIT,
        ST_RESTORE,
        ST_DONE
    } state_e;

endpackage

// File: rtl/dcm_range_calc.sv
module dcm_range_calc #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = LEN_W + 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [CNT_W-1:0]  nlines_o
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SUM_W = LEN_W + 2;

    logic [OFF_W-1:0] slack;
    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] rounded;

    always_comb begin
        slack    = addr_i[OFF_W-1:0];
        base_o   = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        total    = SUM_W'(len_i) + SUM_W'(slack);
        rounded  = total + SUM_W'(LINE_BYTES - 1);
        nlines_o = CNT_W'(rounded >> OFF_W);
    end
endmodule

// File: rtl/dcm_line_walker.sv
module dcm_line_walker #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 17,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  nlines_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  remain_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_o <= '0;
            remain_o   <= '0;
        end else if (load_i) begin
            cur_addr_o <= base_i;
            remain_o   <= nlines_i;
        end else if (step_i) begin
            cur_addr_o <= cur_addr_o + ADDR_W'(LINE_BYTES);
            remain_o   <= remain_o - CNT_W'(1);
        end
    end

    // R2: the walker is never asked to step past its last line
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (remain_o != '0));
endmodule

// File: rtl/dcm_fsm.sv
module dcm_fsm
    import dcm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 17,
    parameter bit SEP_TAG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_whole,
    input  logic [CNT_W-1:0]  nlines_i,
    input  logic [CNT_W-1:0]  remain_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic              flush_busy_i,
    output logic              req_ready,
    output logic              load_o,
    output logic              step_o,
    output logic              cmd_valid_o,
    output cmd_kind_e         cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [CTRL_W-1:0] cmd_data_o,
    output logic              inv_mode_o,
    output logic              done_o
);
    localparam logic [CTRL_W-1:0] CTRL_MODE_SET = CTRL_W'(1) << CTRL_IMODE_BIT;
    localparam logic [CTRL_W-1:0] CTRL_MODE_CLR = '0;
    localparam logic [CTRL_W-1:0] WHOLE_DATA    = CTRL_W'(1);

    state_e     state_q, state_d;
    logic [1:0] op_q;
    logic       whole_q;
    logic       mode_q;
    logic       accept;

    function automatic state_e post_state(input logic [1:0] op);
        return op[1] ? ST_WAIT : ST_DONE;
    endfunction

    function automatic state_e issue_state(input logic [1:0] op, input logic whole,
                                           input logic zero);
        if (whole)     return ST_WHOLE;
        else if (zero) return post_state(op);
        else if (SEP_TAG) return ST_TAG;
        else           return ST_LINE;
    endfunction

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_op == 2'd0)      state_d = ST_DONE;
                    else if (req_op == 2'd3) state_d = ST_SETMODE;
                    else state_d = issue_state(req_op, req_whole, nlines_i == '0);
                end
            end
            ST_SETMODE: state_d = issue_state(op_q, whole_q, remain_i == '0);
            ST_WHOLE:   state_d = post_state(op_q);
            ST_TAG:     state_d = ST_LINE;
            ST_LINE: begin
                if (remain_i == CNT_W'(1)) state_d = post_state(op_q);
                else if (SEP_TAG)          state_d = ST_TAG;
                else                       state_d = ST_LINE;
            end
            ST_WAIT: begin
                if (!flush_busy_i) state_d = (op_q == 2'd3) ? ST_RESTORE : ST_DONE;
            end
            ST_RESTORE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= 2'd0;
            whole_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q    <= req_op;
                whole_q <= req_whole;
            end
            if (state_q == ST_SETMODE) mode_q <= 1'b1;
            if (state_q == ST_RESTORE) mode_q <= 1'b0;
        end
    end

    always_comb begin
        req_ready   = 1'b0;
        load_o      = 1'b0;
        step_o      = 1'b0;
        cmd_valid_o = 1'b0;
        cmd_kind_o  = CK_CTRL;
        cmd_addr_o  = '0;
        cmd_data_o  = '0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                load_o    = accept;
            end
            ST_SETMODE: begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = CK_CTRL;
                cmd_data_o  = CTRL_MODE_SET;
            end
            ST_WHOLE: begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = op_q[0] ? CK_INV_ALL : CK_FLUSH_ALL;
                cmd_data_o  = WHOLE_DATA;
            end
            ST_TAG: begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = CK_TAG;
                cmd_addr_o  = cur_addr_i;
            end
            ST_LINE: begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = op_q[0] ? CK_INV_LINE : CK_FLUSH_LINE;
                cmd_addr_o  = cur_addr_i;
                step_o      = 1'b1;
            end
            ST_WAIT: ;
            ST_RESTORE: begin
                cmd_valid_o = 1'b1;
                cmd_kind_o  = CK_CTRL;
                cmd_data_o  = CTRL_MODE_CLR;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign inv_mode_o = mode_q;

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: mode bit always back to discard when idle
    p_idle_mode_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !inv_mode_o);

    // R6: restore only after the flush status was seen clear
    p_restore_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTORE) |-> $past(!flush_busy_i));

    // R5: plain invalidate never waits on the flush status
    p_plain_inv_no_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> op_q[1]);

    // R4: invalidate commands of code 3 run with the mode bit set
    p_mode_for_wb_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && (op_q == 2'd3) &&
         ((cmd_kind_o == CK_INV_ALL) || (cmd_kind_o == CK_INV_LINE))) |-> inv_mode_o);

    generate
        if (SEP_TAG) begin : g_tag_chk
            // R3: each per-line command follows a tag write of the same address
            p_tag_precedes_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid_o && ((cmd_kind_o == CK_INV_LINE) || (cmd_kind_o == CK_FLUSH_LINE)))
                |-> ($past(cmd_valid_o) && ($past(cmd_kind_o) == CK_TAG) &&
                     ($past(cmd_addr_o) == cmd_addr_o)));
        end
    endgenerate
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
    import dcm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 32,
    parameter bit SEP_TAG    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic              req_whole,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              flush_busy_i,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              inv_mode_o,
    output logic              done_o
);
    localparam int CNT_W = LEN_W + 1;

    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  nlines;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic              load, step;
    cmd_kind_e         kind;
    logic [CTRL_W-1:0] data;

    dcm_range_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)
    ) u_calc (
        .addr_i(req_addr), .len_i(req_len), .base_o(base), .nlines_o(nlines)
    );

    dcm_line_walker #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .base_i(base), .nlines_i(nlines), .cur_addr_o(cur_addr), .remain_o(remain)
    );

    dcm_fsm #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEP_TAG(SEP_TAG)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_whole(req_whole), .nlines_i(nlines), .remain_i(remain),
        .cur_addr_i(cur_addr), .flush_busy_i(flush_busy_i), .req_ready(req_ready),
        .load_o(load), .step_o(step), .cmd_valid_o(cmd_valid), .cmd_kind_o(kind),
        .cmd_addr_o(cmd_addr), .cmd_data_o(data), .inv_mode_o(inv_mode_o),
        .done_o(done_o)
    );

    assign cmd_kind = kind;
    assign cmd_data = data;
endmodule

// File: tb/dcache_maint_ctrl_tb.sv
module dcache_maint_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LB         = 32;
    localparam int BUSY_LEN   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic        req_whole = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        flush_busy_i;
    logic        cmd_valid;
    logic [2:0]  cmd_kind;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_data;
    logic        inv_mode_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int busy_cnt = 0;
    logic force_busy = 1'b0;
    logic busy_ref = 1'b0;
    logic prev_done = 1'b0;
    logic done_seen = 1'b0;
    logic [1:0] cur_op = 2'd0;

    int    q_kind[$];
    int    q_val[$];
    string q_tag[$];

    assign flush_busy_i = (busy_cnt > 0) || force_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcache_maint_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_whole(req_whole), .req_addr(req_addr),
        .req_len(req_len), .flush_busy_i(flush_busy_i), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .inv_mode_o(inv_mode_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input int v, input string tag);
        q_kind.push_back(k);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    // Reference: build the expected command list from the requirements.
    task automatic expect_req(input logic [1:0] op, input logic whole,
                              input int unsigned addr, input int unsigned len);
        int unsigned base, lines;
        if (op == 2'd0) return;                               // R8
        if (op == 2'd3) push(0, 8'h02, "R4");
        if (whole) begin
            push(op[0] ? 1 : 2, 1, "R1");
        end else begin
            base  = addr & ~(LB - 1);
            lines = ((addr % LB) + len + LB - 1) / LB;        // R2, R9
            for (int k = 0; k < int'(lines); k++) begin
                push(3, base + k*LB, "R3");
                push(op[0] ? 4 : 5, base + k*LB, "R2");
            end
        end
        if (op == 2'd3) push(0, 8'h00, "R6");
    endtask

    task automatic run(input logic [1:0] op, input logic whole,
                       input int unsigned addr, input int unsigned len);
        expect_req(op, whole, addr, len);
        @(negedge clk);
        cur_op    = op;
        done_seen = 1'b0;
        req_valid = 1'b1;
        req_op    = op;
        req_whole = whole;
        req_addr  = addr;
        req_len   = 16'(len);
        @(posedge clk);
        #1 busy_ref = 1'b1;
        @(negedge clk);
        // R7: a different request held while busy must be ignored
        req_op    = (op == 2'd2) ? 2'd1 : 2'd2;
        req_whole = ~whole;
        req_addr  = 32'h0000_5004;
        req_len   = 16'h0100;
        wait (done_seen);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_ready === !busy_ref, "R7 ready", req_ready, !busy_ref);
            if (!busy_ref) chk(inv_mode_o == 1'b0, "R6 idle mode", inv_mode_o, 0);
            if (cmd_valid) begin
                if (q_kind.size() == 0) begin
                    chk(1'b0, "R7 unexpected cmd", cmd_kind, 7);
                end else begin
                    int k, v; string t;
                    k = q_kind.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
                    chk(int'(cmd_kind) == k, {t, " kind"}, cmd_kind, k);
                    if (k == 3 || k == 4 || k == 5)
                        chk(cmd_addr == 32'(v), {t, " addr"}, cmd_addr, v);
                    else
                        chk(int'(cmd_data) == v, {t, " data"}, cmd_data, v);
                    if (k == 4 || (k == 1 && cur_op == 2'd3))
                        if (cur_op == 2'd3) chk(inv_mode_o, "R4 mode", inv_mode_o, 1);
                    if (k == 0 && v == 0)
                        chk(!flush_busy_i, "R6 restore after drain", flush_busy_i, 0);
                end
            end
            if (done_o) begin
                chk(!prev_done, "R7 done pulse", prev_done, 0);
                chk(q_kind.size() == 0, "R2 missing cmds", q_kind.size(), 0);
                if (cur_op[1]) chk(!flush_busy_i, "R5 wait for drain", flush_busy_i, 0);
                busy_ref  = 1'b0;
                done_seen = 1'b1;
            end
            prev_done = done_o;
            // cache unit model: flushes keep the status busy for a while
            if (cmd_valid && (cmd_kind == 3'd2 || cmd_kind == 3'd5 ||
                ((cmd_kind == 3'd1 || cmd_kind == 3'd4) && inv_mode_o)))
                busy_cnt = BUSY_LEN;
            else if (busy_cnt > 0)
                busy_cnt = busy_cnt - 1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R7 reset ready", req_ready, 1);
        chk(cmd_valid == 1'b0, "R7 reset cmd", cmd_valid, 0);
        chk(done_o == 1'b0, "R7 reset done", done_o, 0);
        chk(inv_mode_o == 1'b0, "R6 reset mode", inv_mode_o, 0);

        run(2'd1, 1'b1, 0, 0);                    // R1 invalidate-all
        run(2'd2, 1'b1, 0, 0);                    // R1 flush-all, R5 wait
        run(2'd3, 1'b1, 0, 0);                    // R4 R6 whole
        run(2'd1, 1'b0, 32'h1000, 64);            // R2 aligned, two lines
        run(2'd2, 1'b0, 32'h1014, 32'h30);        // R2 unaligned, three lines
        run(2'd3, 1'b0, 32'h2001, 1);             // R4 R6 range, one line
        run(2'd2, 1'b0, 32'h3000, 0);             // R9 empty range
        run(2'd1, 1'b0, 32'h3005, 0);             // R2 slack alone gives a line
        run(2'd1, 1'b0, 32'h3000, 32'h20);        // R2 exact line end
        run(2'd0, 1'b1, 0, 0);                    // R8 no-op
        run(2'd0, 1'b0, 32'h4000, 64);            // R8 no-op range
        force_busy = 1'b1;
        run(2'd1, 1'b1, 0, 0);                    // R5 plain invalidate ignores busy
        run(2'd1, 1'b0, 32'h4010, 32'h40);        // R5 range under busy
        force_busy = 1'b0;
        run(2'd3, 1'b0, 32'h5010, 32'h31);        // R3 R4 R6 multi-line

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule